// File: doc/BRIEF.md
# Detour Scratch Register File

This block holds the private working registers used by hardware substitution routines. Such a routine replaces an instruction whose functional unit is known to be broken. While a routine runs, the core is in detour mode. In that mode every register specifier from decode and every result write from execute is steered to a small scratch file, so the architected registers stay untouched. Outside detour mode the block is transparent: architected read data and result writes pass straight through it.

A routine begins with a start pulse, which carries the two source specifiers of the replaced instruction, their bypassed values and its destination index. In that cycle the block captures both operands into the two lowest scratch slots. If execute writes one of those architected registers in the same cycle, the freshly written value is captured instead. A routine ends with a finish pulse. In the finish cycle the fixed result slot is written back to the saved destination for one cycle. If the replaced instruction was a control transfer, the result is presented as a new program counter instead. The highest scratch slot always reads as zero, which matches the architected zero register, so a routine can name zero in the same way in either mode.

Top module: `detour_scratch_regs`

## Requirements
- R1: After reset detour_o is low and every scratch slot holds zero.
- R2: With detour_o high, rd_a_data_o and rd_b_data_o return the scratch slot selected by the low 3 bits of the read specifier. With detour_o low, they return arch_rd_a_i and arch_rd_b_i unchanged.
- R3: Scratch slot 7 always reads zero. A write aimed at it is dropped.
- R4: A start_i seen while detour_o is low loads slot 0 from operand A and slot 1 from operand B. detour_o rises on the next cycle.
- R5: The operand captured at start comes from wr_data_i when wr_en_i is high and wr_idx_i equals that source specifier. A source specifier of 31 (the architected zero register) captures 0. Otherwise the bypassed value input is captured.
- R6: With detour_o high, a result write (wr_en_i) updates the scratch slot given by the low 3 bits of wr_idx_i. Outside the copy-back, arch_we_o stays low in detour mode. With detour_o low, wr_en_i, wr_idx_i and wr_data_i appear unchanged on arch_we_o, arch_widx_o and arch_wdata_o.
- R7: A finish_i seen while detour_o is high, for a routine started without is_ctrl_i, raises arch_we_o in that same cycle. It carries the destination index saved at start and the value in slot 2. detour_o falls on the next cycle.
- R8: For a routine started with is_ctrl_i high, the finish cycle raises pc_we_o with pc_data_o equal to slot 2, and arch_we_o stays low. pc_we_o is never high outside such a finish cycle.
- R9: start_i while detour_o is high, and finish_i while detour_o is low, change no state and produce no copy-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Routine start pulse |
| finish_i | input | 1 | Routine end pulse |
| is_ctrl_i | input | 1 | Replaced instruction is a control transfer (sampled at start) |
| src_a_idx_i | input | 5 | Architected specifier of operand A |
| src_b_idx_i | input | 5 | Architected specifier of operand B |
| src_a_val_i | input | 32 | Bypassed value of operand A |
| src_b_val_i | input | 32 | Bypassed value of operand B |
| dst_idx_i | input | 5 | Architected destination of the replaced instruction |
| rd_a_idx_i | input | 5 | Decode read specifier A |
| rd_b_idx_i | input | 5 | Decode read specifier B |
| arch_rd_a_i | input | 32 | Architected file read data A |
| arch_rd_b_i | input | 32 | Architected file read data B |
| wr_en_i | input | 1 | Result write enable from execute |
| wr_idx_i | input | 5 | Result write specifier |
| wr_data_i | input | 32 | Result write data |
| rd_a_data_o | output | 32 | Operand A to execute |
| rd_b_data_o | output | 32 | Operand B to execute |
| arch_we_o | output | 1 | Architected file write enable |
| arch_widx_o | output | 5 | Architected file write index |
| arch_wdata_o | output | 32 | Architected file write data |
| pc_we_o | output | 1 | Program counter load from routine result |
| pc_data_o | output | 32 | Program counter value |
| detour_o | output | 1 | Detour mode active |

## Verification
The assertions check several rules on every cycle. Mode entry follows an accepted start and mode exit follows an accepted finish. An ignored start leaves the mode as it is. Reads of slot 7 give zero, and arch reads pass through unchanged outside detour mode. Architected writes are blocked in detour mode except during copy-back. The program counter load is exclusive with the architected write and happens only in a finish cycle. The bench scenarios are what show where values go. They check that the two operands, including the same-cycle bypass and the zero-register source, land in slots 0 and 1. They check that routine writes reach the right slot and that the copy-back carries the saved destination and the slot 2 value.

// File: rtl/dsr_pkg.sv
// dsr_pkg: shared constants and types of the detour scratch register file.
// Assumes the operand slots sit at the bottom of the scratch file.
package dsr_pkg;
    localparam int OPA_SLOT = 0;
    localparam int OPB_SLOT = 1;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_DETOUR = 1'b1
    } mode_e;
endpackage

// File: rtl/dsr_operand_sel.sv
// dsr_operand_sel: picks the value captured for one source operand at
// routine start. A same-cycle result write to that register wins over the
// bypassed input, and the architected zero register captures zero.
// Assumes the write port is only meaningful outside detour mode.
module dsr_operand_sel #(
    parameter int XLEN     = 32,
    parameter int AW       = 5,
    parameter int ZERO_IDX = 31
) (
    input  logic [AW-1:0]   src_idx_i,
    input  logic [XLEN-1:0] src_val_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_idx_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [XLEN-1:0] val_o
);
    // Purpose: priority select zero > same-cycle write > bypassed value.
    always_comb begin
        if (src_idx_i == AW'(ZERO_IDX))
            val_o = '0;
        else if (wr_en_i && (wr_idx_i == src_idx_i))
            val_o = wr_data_i;
        else
            val_o = src_val_i;
    end
endmodule

// File: rtl/dsr_store.sv
// dsr_store: scratch slot storage with two read ports, one result read
// port, one write port and a paired operand load. The top slot is a
// constant zero. Assumes load and write never target the same cycle.
module dsr_store #(
    parameter int XLEN     = 32,
    parameter int SLOTS    = 8,
    parameter int RES_SLOT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [XLEN-1:0]          load_a_i,
    input  logic [XLEN-1:0]          load_b_i,
    input  logic                     we_i,
    input  logic [$clog2(SLOTS)-1:0] widx_i,
    input  logic [XLEN-1:0]          wdata_i,
    input  logic [$clog2(SLOTS)-1:0] ra_idx_i,
    input  logic [$clog2(SLOTS)-1:0] rb_idx_i,
    output logic [XLEN-1:0]          ra_o,
    output logic [XLEN-1:0]          rb_o,
    output logic [XLEN-1:0]          res_o
);
    import dsr_pkg::*;
    localparam int SW       = $clog2(SLOTS);
    localparam int ZERO_SLT = SLOTS - 1;

    logic [SLOTS-1:0][XLEN-1:0] slot_w;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g == ZERO_SLT) begin : g_zero
            assign slot_w[g] = '0;
        end else begin : g_reg
            logic [XLEN-1:0] q;
            // Purpose: hold one slot; operand load beats routine write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (load_i && (g == OPA_SLOT))
                    q <= load_a_i;
                else if (load_i && (g == OPB_SLOT))
                    q <= load_b_i;
                else if (we_i && (widx_i == SW'(g)))
                    q <= wdata_i;
            end
            assign slot_w[g] = q;
        end
    end

    assign ra_o  = slot_w[ra_idx_i];
    assign rb_o  = slot_w[rb_idx_i];
    assign res_o = slot_w[RES_SLOT];
endmodule

// File: rtl/dsr_seq.sv
// dsr_seq: mode sequencer. Accepts a start only in normal mode and a
// finish only in detour mode. It keeps the destination and the control
// flag of the replaced instruction and issues the one-cycle copy-back or
// program counter load in the finish cycle.
module dsr_seq #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          finish_i,
    input  logic          is_ctrl_i,
    input  logic [AW-1:0] dst_idx_i,
    output logic          detour_o,
    output logic          copyin_o,
    output logic          copyback_o,
    output logic          pc_load_o,
    output logic [AW-1:0] saved_dst_o
);
    import dsr_pkg::*;
    mode_e mode_q;
    logic  ctrl_q;

    assign detour_o    = (mode_q == MODE_DETOUR);
    assign copyin_o    = (mode_q == MODE_NORMAL) && start_i;
    assign copyback_o  = detour_o && finish_i && !ctrl_q;
    assign pc_load_o   = detour_o && finish_i && ctrl_q;

    // Purpose: advance the mode and latch the routine context at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_NORMAL;
            ctrl_q      <= 1'b0;
            saved_dst_o <= '0;
        end else if (copyin_o) begin
            mode_q      <= MODE_DETOUR;
            ctrl_q      <= is_ctrl_i;
            saved_dst_o <= dst_idx_i;
        end else if (detour_o && finish_i) begin
            mode_q      <= MODE_NORMAL;
        end
    end
endmodule

// File: rtl/detour_scratch_regs.sv
// detour_scratch_regs: private register file for substitution routines.
// It steers reads and writes to scratch slots in detour mode, captures the
// two operands at start and copies the result slot back at finish.
// Assumes the architected zero register is the highest architected index
// and that routines only name slots through the low specifier bits.
module detour_scratch_regs #(
    parameter int XLEN      = 32,
    parameter int ARCH_REGS = 32,
    parameter int AUX_REGS  = 8,
    parameter int RES_SLOT  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         finish_i,
    input  logic                         is_ctrl_i,
    input  logic [$clog2(ARCH_REGS)-1:0] src_a_idx_i,
    input  logic [$clog2(ARCH_REGS)-1:0] src_b_idx_i,
    input  logic [XLEN-1:0]              src_a_val_i,
    input  logic [XLEN-1:0]              src_b_val_i,
    input  logic [$clog2(ARCH_REGS)-1:0] dst_idx_i,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_a_idx_i,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_b_idx_i,
    input  logic [XLEN-1:0]              arch_rd_a_i,
    input  logic [XLEN-1:0]              arch_rd_b_i,
    input  logic                         wr_en_i,
    input  logic [$clog2(ARCH_REGS)-1:0] wr_idx_i,
    input  logic [XLEN-1:0]              wr_data_i,
    output logic [XLEN-1:0]              rd_a_data_o,
    output logic [XLEN-1:0]              rd_b_data_o,
    output logic                         arch_we_o,
    output logic [$clog2(ARCH_REGS)-1:0] arch_widx_o,
    output logic [XLEN-1:0]              arch_wdata_o,
    output logic                         pc_we_o,
    output logic [XLEN-1:0]              pc_data_o,
    output logic                         detour_o
);
    localparam int AW       = $clog2(ARCH_REGS);
    localparam int SW       = $clog2(AUX_REGS);
    localparam int ZERO_IDX = ARCH_REGS - 1;

    logic          copyin, copyback;
    logic [AW-1:0] saved_dst;
    logic [XLEN-1:0] aux_ra, aux_rb, aux_res;
    logic [1:0][AW-1:0]   op_idx;
    logic [1:0][XLEN-1:0] op_val, op_cap;

    assign op_idx = {src_b_idx_i, src_a_idx_i};
    assign op_val = {src_b_val_i, src_a_val_i};

    dsr_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .finish_i   (finish_i),
        .is_ctrl_i  (is_ctrl_i),
        .dst_idx_i  (dst_idx_i),
        .detour_o   (detour_o),
        .copyin_o   (copyin),
        .copyback_o (copyback),
        .pc_load_o  (pc_we_o),
        .saved_dst_o(saved_dst)
    );

    for (genvar k = 0; k < 2; k++) begin : g_op
        dsr_operand_sel #(.XLEN(XLEN), .AW(AW), .ZERO_IDX(ZERO_IDX)) u_sel (
            .src_idx_i (op_idx[k]),
            .src_val_i (op_val[k]),
            .wr_en_i   (wr_en_i),
            .wr_idx_i  (wr_idx_i),
            .wr_data_i (wr_data_i),
            .val_o     (op_cap[k])
        );
    end

    dsr_store #(.XLEN(XLEN), .SLOTS(AUX_REGS), .RES_SLOT(RES_SLOT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (copyin),
        .load_a_i (op_cap[0]),
        .load_b_i (op_cap[1]),
        .we_i     (detour_o && wr_en_i),
        .widx_i   (wr_idx_i[SW-1:0]),
        .wdata_i  (wr_data_i),
        .ra_idx_i (rd_a_idx_i[SW-1:0]),
        .rb_idx_i (rd_b_idx_i[SW-1:0]),
        .ra_o     (aux_ra),
        .rb_o     (aux_rb),
        .res_o    (aux_res)
    );

    // Purpose: steer operand reads and the architected write port by mode.
    always_comb begin
        rd_a_data_o = detour_o ? aux_ra : arch_rd_a_i;
        rd_b_data_o = detour_o ? aux_rb : arch_rd_b_i;
        if (detour_o) begin
            arch_we_o    = copyback;
            arch_widx_o  = saved_dst;
            arch_wdata_o = aux_res;
        end else begin
            arch_we_o    = wr_en_i;
            arch_widx_o  = wr_idx_i;
            arch_wdata_o = wr_data_i;
        end
    end

    assign pc_data_o = aux_res;
endmodule

// File: rtl/dsr_checker.sv
// dsr_checker: cycle-level properties of detour_scratch_regs, bound in.
module dsr_checker #(
    parameter int XLEN     = 32,
    parameter int AW       = 5,
    parameter int AUX_REGS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            finish_i,
    input logic [AW-1:0]   rd_a_idx_i,
    input logic [XLEN-1:0] arch_rd_a_i,
    input logic [XLEN-1:0] rd_a_data_o,
    input logic            arch_we_o,
    input logic            pc_we_o,
    input logic            detour_o
);
    localparam int SW = $clog2(AUX_REGS);

    p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !detour_o |=> detour_o);
    p_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        detour_o && finish_i |=> !detour_o);
    p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        detour_o && start_i && !finish_i |=> detour_o);
    p_no_arch_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        detour_o && !finish_i |-> !arch_we_o);
    p_pc_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |-> (!arch_we_o && detour_o && finish_i));
    p_zero_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        detour_o && (rd_a_idx_i[SW-1:0] == SW'(AUX_REGS-1)) |-> rd_a_data_o == '0);
    p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !detour_o |-> rd_a_data_o == arch_rd_a_i);
endmodule

bind detour_scratch_regs dsr_checker #(.XLEN(XLEN), .AW($clog2(ARCH_REGS)), .AUX_REGS(AUX_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .finish_i   (finish_i),
    .rd_a_idx_i (rd_a_idx_i),
    .arch_rd_a_i(arch_rd_a_i),
    .rd_a_data_o(rd_a_data_o),
    .arch_we_o  (arch_we_o),
    .pc_we_o    (pc_we_o),
    .detour_o   (detour_o)
);

// File: tb/detour_scratch_regs_test.sv
module detour_scratch_regs_test;
    localparam int CLK_T = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic start_i, finish_i, is_ctrl_i, wr_en_i;
    logic [4:0] src_a_idx_i, src_b_idx_i, dst_idx_i, rd_a_idx_i, rd_b_idx_i, wr_idx_i;
    logic [31:0] src_a_val_i, src_b_val_i, arch_rd_a_i, arch_rd_b_i, wr_data_i;
    logic [31:0] rd_a_data_o, rd_b_data_o, arch_wdata_o, pc_data_o;
    logic arch_we_o, pc_we_o, detour_o;
    logic [4:0] arch_widx_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_aux [8];
    bit m_det, m_ctrl;
    logic [4:0] m_dst;

    always #(CLK_T/2) clk = ~clk;

    detour_scratch_regs uut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [4:0] idx, input logic [31:0] arch);
        if (!m_det) return arch;
        if (idx[2:0] == 3'd7) return 32'd0;
        return m_aux[idx[2:0]];
    endfunction

    function automatic logic [31:0] m_cap(input logic [4:0] idx, input logic [31:0] v);
        if (idx == 5'd31) return 32'd0;
        if (wr_en_i && wr_idx_i == idx) return wr_data_i;
        return v;
    endfunction

    task automatic compare();
        logic ewe, epc;
        ewe = m_det ? (finish_i && !m_ctrl) : wr_en_i;
        epc = m_det && finish_i && m_ctrl;
        check(detour_o == m_det, "R1/R4/R7/R9 detour_o", 32'(detour_o), 32'(m_det));
        check(rd_a_data_o == m_read(rd_a_idx_i, arch_rd_a_i), "R2/R3 rd_a", rd_a_data_o, m_read(rd_a_idx_i, arch_rd_a_i));
        check(rd_b_data_o == m_read(rd_b_idx_i, arch_rd_b_i), "R2/R3 rd_b", rd_b_data_o, m_read(rd_b_idx_i, arch_rd_b_i));
        check(arch_we_o == ewe, "R6/R7 arch_we", 32'(arch_we_o), 32'(ewe));
        if (ewe) begin
            check(arch_widx_o == (m_det ? m_dst : wr_idx_i), "R6/R7 arch_widx",
                  32'(arch_widx_o), 32'(m_det ? m_dst : wr_idx_i));
            check(arch_wdata_o == (m_det ? m_aux[2] : wr_data_i), "R6/R7 arch_wdata",
                  arch_wdata_o, m_det ? m_aux[2] : wr_data_i);
        end
        check(pc_we_o == epc, "R8 pc_we", 32'(pc_we_o), 32'(epc));
        if (epc) check(pc_data_o == m_aux[2], "R8 pc_data", pc_data_o, m_aux[2]);
    endtask

    task automatic update();
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_aux[i] = '0;
            m_det = 0; m_ctrl = 0; m_dst = '0;
        end else if (m_det) begin
            if (wr_en_i && wr_idx_i[2:0] != 3'd7) m_aux[wr_idx_i[2:0]] = wr_data_i;
            if (finish_i) m_det = 0;
        end else if (start_i) begin
            m_aux[0] = m_cap(src_a_idx_i, src_a_val_i);
            m_aux[1] = m_cap(src_b_idx_i, src_b_val_i);
            m_det = 1; m_ctrl = is_ctrl_i; m_dst = dst_idx_i;
        end
    endtask

    // Called just after a negedge with inputs already set.
    task automatic cyc();
        #(CLK_T/4);
        if (rst_n) compare();
        @(posedge clk); #1;
        update();
        @(negedge clk);
    endtask

    task automatic idle();
        start_i = 0; finish_i = 0; is_ctrl_i = 0; wr_en_i = 0;
        src_a_idx_i = 0; src_b_idx_i = 0; dst_idx_i = 0;
        rd_a_idx_i = 0; rd_b_idx_i = 0; wr_idx_i = 0;
        src_a_val_i = 0; src_b_val_i = 0; wr_data_i = 0;
        arch_rd_a_i = $urandom; arch_rd_b_i = $urandom;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        cyc(); cyc();
        #(CLK_T/4);
        check(detour_o == 1'b0, "R1 detour low in reset", 32'(detour_o), 0);
        @(negedge clk);
        rst_n = 1;

        // R2/R6: normal mode pass-through
        idle(); rd_a_idx_i = 5'd3; rd_b_idx_i = 5'd9;
        wr_en_i = 1; wr_idx_i = 5'd4; wr_data_i = 32'hA5A5_0001; cyc();

        // R4/R5: start with a same-cycle write to source A (bypass)
        idle(); start_i = 1; dst_idx_i = 5'd12;
        src_a_idx_i = 5'd6; src_a_val_i = 32'h1111_1111;
        src_b_idx_i = 5'd7; src_b_val_i = 32'h2222_2222;
        wr_en_i = 1; wr_idx_i = 5'd6; wr_data_i = 32'hBEEF_0006; cyc();

        // R1/R2: read operand slots and an untouched slot
        idle(); rd_a_idx_i = 5'd0; rd_b_idx_i = 5'd1; cyc();
        idle(); rd_a_idx_i = 5'd3; rd_b_idx_i = 5'd6; cyc();
        // R9: restart in detour ignored
        idle(); start_i = 1; src_a_idx_i = 5'd2; src_a_val_i = 32'hDEAD; dst_idx_i = 5'd1; cyc();
        // R6/R3: routine writes to slot 2 and to slot 7
        idle(); wr_en_i = 1; wr_idx_i = 5'd2; wr_data_i = 32'h0000_C0DE; cyc();
        idle(); wr_en_i = 1; wr_idx_i = 5'd7; wr_data_i = 32'hFFFF_FFFF; cyc();
        idle(); rd_a_idx_i = 5'd7; rd_b_idx_i = 5'd31; cyc();
        idle(); rd_a_idx_i = 5'd2; rd_b_idx_i = 5'd0; cyc();
        // R7: finish with copy-back to saved destination 12
        idle(); finish_i = 1; cyc();
        // R9: finish in normal mode ignored
        idle(); finish_i = 1; rd_a_idx_i = 5'd2; cyc();

        // R5/R8: control-flow routine, source A is zero register
        idle(); start_i = 1; is_ctrl_i = 1; dst_idx_i = 5'd5;
        src_a_idx_i = 5'd31; src_a_val_i = 32'h7777_7777;
        src_b_idx_i = 5'd3; src_b_val_i = 32'h3333_3333; cyc();
        idle(); rd_a_idx_i = 5'd0; rd_b_idx_i = 5'd1; cyc();
        idle(); wr_en_i = 1; wr_idx_i = 5'd2; wr_data_i = 32'h0040_1000; cyc();
        idle(); finish_i = 1; cyc();
        idle(); cyc();

        // Mixed traffic for every requirement
        for (int n = 0; n < 400; n++) begin
            idle();
            start_i = ($urandom % 6) == 0;
            finish_i = ($urandom % 5) == 0;
            is_ctrl_i = $urandom; wr_en_i = $urandom;
            src_a_idx_i = $urandom; src_b_idx_i = $urandom; dst_idx_i = $urandom;
            rd_a_idx_i = $urandom; rd_b_idx_i = $urandom; wr_idx_i = $urandom;
            src_a_val_i = $urandom; src_b_val_i = $urandom; wr_data_i = $urandom;
            if (($urandom % 3) == 0) wr_idx_i = src_b_idx_i;
            cyc();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule